// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block holds a chain of storage stages that is filled all at once from a parallel input word and then drained one bit at a time through a serial output, with a complemented copy of that output beside it. While the stages drain, fresh bits enter from a serial input at the far end of the chain. It is used to turn a wide word into a bit stream, and several blocks can be cascaded by feeding one block's serial output into the next block's serial input.

The shift clock, the clock-inhibit input, the load control and the serial input all come from outside the system-clock domain. Each passes through a two-flop synchronizer. The synchronized shift clock and inhibit are OR-combined into one gated level, and a rising edge of that level, found by comparing it with its value one system cycle earlier, requests one shift. The load control is level-sensitive: while it is low the stages follow the parallel inputs on every system cycle and all shift requests are dropped.

Top module: `piso_shifter`

## Requirements
- R1: A synchronous active-high reset clears every stage, so `serOut` reads 0 and `serOutN` reads 1 after reset.
- R2: While `loadN` is low, every stage copies `parIn` on every system cycle, whatever the levels on `shClk`, `shInhibit` and `serIn`; a change of `parIn` during the load shows up at the output.
- R3: While `loadN` is high, changes on `parIn` have no effect on the stages.
- R4: With `loadN` high and `shInhibit` low, a low-to-high transition of `shClk` moves the data one stage toward `serOut`.
- R5: With `loadN` high and `shClk` low, a low-to-high transition of `shInhibit` also moves the data one stage, so the two inputs are interchangeable.
- R6: While either `shClk` or `shInhibit` is held high, transitions on the other input cause no shift.
- R7: `parIn[STAGES-1]` appears at `serOut` straight after a load, `parIn[0]` appears after `STAGES-1` shifts, and the bit on `serIn` at the first shift appears after `STAGES` shifts.
- R8: `serOutN` is the logical complement of `serOut` at all times.
- R9: A rising gated-clock level that arrives while the load control is low is consumed by the load; releasing the load with the clock still high does not shift.
- R10: A gated-clock level that is already high when reset is released does not count as an edge, so no shift follows reset until the level falls and rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| shClk | input | 1 | Asynchronous shift clock, rising transition requests a shift |
| shInhibit | input | 1 | Asynchronous inhibit, OR-combined with `shClk` |
| loadN | input | 1 | Asynchronous load control, low loads `parIn`, high allows shifting |
| serIn | input | 1 | Asynchronous serial data entering stage 0 on each shift |
| parIn | input | STAGES | Parallel data; bit 0 is farthest from the output |
| serOut | output | 1 | Content of the last stage |
| serOutN | output | 1 | Complement of `serOut` |

## Verification
The hardest situation to create is a gated-clock edge that coincides with reset release or with an active load, because the edge is then swallowed and leaves no trace unless later data movement shows it. The stimulus holds `shClk` high through reset with `serIn` at 1, then shifts zeros `STAGES-1` times: a spurious shift would have planted a 1 that now reaches `serOut`. For the load case, `shClk` rises while `loadN` is low and `loadN` is then released with the clock still high, so an extra shift would expose bit `STAGES-2` instead of the top bit. A sweep over all 256 load words drains each one fully, alternating the clock source between the two inputs.

// File: rtl/piso_pkg.sv
`timescale 1ns/1ps
package piso_pkg;
  // strobes from control to the stage register
  typedef struct packed {
    logic load;
    logic shift;
  } stageCmd_t;
endpackage

// File: rtl/piso_sync.sv
`timescale 1ns/1ps
module piso_sync #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [DEPTH-1:0][WIDTH-1:0] chain;

  // free-running chain: it keeps sampling during reset so its output is
  // settled by the time reset is released
  always_ff @(posedge clk) begin
    chain[0] <= asyncIn;
    for (int i = 1; i < DEPTH; i++) begin
      chain[i] <= chain[i-1];
    end
  end

  assign syncOut = chain[DEPTH-1];
endmodule

// File: rtl/piso_ctrl.sv
`timescale 1ns/1ps
module piso_ctrl
  import piso_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      shClk,
  input  logic      shInhibit,
  input  logic      loadN,
  input  logic      serIn,
  output stageCmd_t cmd,
  output logic      serSync
);
  localparam int NUM_IN = 4;

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] syncIn;
  logic              clkSync;
  logic              inhSync;
  logic              loadNSync;
  logic              gatedLvl;
  logic              prevLvl;

  assign rawIn = {serIn, loadN, shInhibit, shClk};

  piso_sync #(.WIDTH(NUM_IN), .DEPTH(SYNC_DEPTH)) uSync (
    .clk     (clk),
    .asyncIn (rawIn),
    .syncOut (syncIn)
  );

  assign clkSync   = syncIn[0];
  assign inhSync   = syncIn[1];
  assign loadNSync = syncIn[2];
  assign serSync   = syncIn[3];

  // interchangeable clock inputs (R4, R5, R6)
  assign gatedLvl = clkSync | inhSync;

  // previous level follows the present level during reset too, so a level
  // already high at release is not an edge (R10)
  always_ff @(posedge clk) begin
    if (rst) prevLvl <= gatedLvl;
    else     prevLvl <= gatedLvl;
  end

  // load overrides any edge and consumes it (R2, R9)
  always_comb begin
    cmd.load  = ~loadNSync;
    cmd.shift = loadNSync & gatedLvl & ~prevLvl;
  end
endmodule

// File: rtl/piso_datapath.sv
`timescale 1ns/1ps
module piso_datapath
  import piso_pkg::*;
#(
  parameter int STAGES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  stageCmd_t         cmd,
  input  logic              serBit,
  input  logic [STAGES-1:0] parIn,
  output logic [STAGES-1:0] stageQ
);
  // stage 0 is fed by the serial input, stage STAGES-1 drives the output (R7)
  always_ff @(posedge clk) begin
    if (rst)            stageQ <= '0;
    else if (cmd.load)  stageQ <= parIn;
    else if (cmd.shift) stageQ <= {stageQ[STAGES-2:0], serBit};
  end
endmodule

// File: rtl/piso_shifter.sv
`timescale 1ns/1ps
module piso_shifter
  import piso_pkg::*;
#(
  parameter int STAGES     = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shClk,
  input  logic              shInhibit,
  input  logic              loadN,
  input  logic              serIn,
  input  logic [STAGES-1:0] parIn,
  output logic              serOut,
  output logic              serOutN
);
  stageCmd_t         cmd;
  logic              serSync;
  logic [STAGES-1:0] stageQ;

  piso_ctrl #(.SYNC_DEPTH(SYNC_DEPTH)) uCtrl (
    .clk       (clk),
    .rst       (rst),
    .shClk     (shClk),
    .shInhibit (shInhibit),
    .loadN     (loadN),
    .serIn     (serIn),
    .cmd       (cmd),
    .serSync   (serSync)
  );

  piso_datapath #(.STAGES(STAGES)) uData (
    .clk    (clk),
    .rst    (rst),
    .cmd    (cmd),
    .serBit (serSync),
    .parIn  (parIn),
    .stageQ (stageQ)
  );

  assign serOut  = stageQ[STAGES-1];
  assign serOutN = ~stageQ[STAGES-1]; // R8
endmodule

// File: rtl/piso_chk.sv
`timescale 1ns/1ps
module piso_chk
  import piso_pkg::*;
#(
  parameter int STAGES = 8
) (
  input logic              clk,
  input logic              rst,
  input stageCmd_t         cmd,
  input logic              serSync,
  input logic [STAGES-1:0] parIn,
  input logic [STAGES-1:0] stageQ,
  input logic              serOut,
  input logic              serOutN
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (serOut == 1'b0 && serOutN == 1'b1));

  // R2
  load_follow_chk: assert property (@(posedge clk) disable iff (rst)
    cmd.load |=> (stageQ == $past(parIn)));

  // R4
  shift_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd.shift && !cmd.load) |=> (stageQ == {$past(stageQ[STAGES-2:0]), $past(serSync)}));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cmd.load && !cmd.shift) |=> $stable(stageQ));
endmodule

bind piso_shifter piso_chk #(.STAGES(STAGES)) uChk (
  .clk     (clk),
  .rst     (rst),
  .cmd     (cmd),
  .serSync (serSync),
  .parIn   (parIn),
  .stageQ  (stageQ),
  .serOut  (serOut),
  .serOutN (serOutN)
);

// File: tb/sim_piso_shifter.sv
`timescale 1ns/1ps
module sim_piso_shifter;
  localparam int STAGES = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              shClk = 1'b0;
  logic              shInhibit = 1'b0;
  logic              loadN = 1'b1;
  logic              serIn = 1'b0;
  logic [STAGES-1:0] parIn = '0;
  logic              serOut;
  logic              serOutN;

  int checks = 0;
  int errors = 0;
  logic [STAGES-1:0] model;
  bit done = 1'b0;

  always #5 clk = ~clk;

  piso_shifter #(.STAGES(STAGES)) u0 (
    .clk, .rst, .shClk, .shInhibit, .loadN, .serIn, .parIn, .serOut, .serOutN
  );

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic checkOut(input string req);
    check(serOut, model[STAGES-1], req);
    check(serOutN, ~model[STAGES-1], "R8");
  endtask

  task automatic doLoad(input logic [STAGES-1:0] v);
    parIn = v;
    loadN = 1'b0;
    settle();
    loadN = 1'b1;
    settle();
    model = v;
  endtask

  task automatic pulse(input bit useInh);
    if (useInh) shInhibit = 1'b1; else shClk = 1'b1;
    settle();
    model = {model[STAGES-2:0], serIn};
    if (useInh) shInhibit = 1'b0; else shClk = 1'b0;
    settle();
  endtask

  initial begin
    #1ms;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // reset with the gated clock already high and serial input at 1
    shClk = 1'b1;
    serIn = 1'b1;
    repeat (6) @(negedge clk);
    rst = 1'b0;
    settle();
    model = '0;
    // R1 reset state
    check(serOut, 1'b0, "R1");
    check(serOutN, 1'b1, "R1");
    serIn = 1'b0;
    settle();
    shClk = 1'b0;
    settle();
    // R10: a false shift would have planted a 1 that now reaches the output
    for (int k = 0; k < STAGES - 1; k++) pulse(1'b0);
    check(serOut, 1'b0, "R10");

    // sweep all load words, draining each fully
    for (int v = 0; v < 256; v++) begin
      logic [STAGES-1:0] w;
      w = STAGES'(v);
      doLoad(w);
      check(serOut, w[STAGES-1], "R7");
      checkOut("R7");
      for (int k = 0; k < STAGES; k++) begin
        bit useInh;
        useInh = bit'(w[0] ^ k[0]);
        serIn = ~w[k];
        pulse(useInh);
        checkOut(useInh ? "R5" : "R4");
        if (k == STAGES - 2) check(serOut, w[0], "R7");
        if (k == STAGES - 1) check(serOut, ~w[0], "R7");
      end
    end

    // R2: load is level-sensitive and ignores clock, inhibit and serial
    parIn = 8'hA5;
    loadN = 1'b0;
    shClk = 1'b1; serIn = 1'b0;
    settle();
    shClk = 1'b0; shInhibit = 1'b1; serIn = 1'b1;
    settle();
    check(serOut, 1'b1, "R2");
    parIn = 8'h5A;
    shInhibit = 1'b0;
    settle();
    check(serOut, 1'b0, "R2");
    check(serOutN, 1'b1, "R2");

    // R9: clock rises during load, load released with clock still high
    parIn = 8'h80;
    settle();
    shClk = 1'b1;
    settle();
    loadN = 1'b1;
    settle();
    model = 8'h80;
    check(serOut, 1'b1, "R9");
    shClk = 1'b0;
    settle();
    check(serOut, 1'b1, "R9");

    // R3: parallel input ignored while load is high
    doLoad(8'hFF);
    parIn = 8'h00;
    settle();
    check(serOut, 1'b1, "R3");
    serIn = 1'b0;
    pulse(1'b0);
    check(serOut, 1'b1, "R3");
    checkOut("R3");

    // R6: one input held high blocks the other
    doLoad(8'hAA);
    shClk = 1'b1;
    settle();
    model = {model[STAGES-2:0], serIn};
    checkOut("R4");
    for (int k = 0; k < 3; k++) begin
      shInhibit = 1'b1; settle();
      shInhibit = 1'b0; settle();
      checkOut("R6");
    end
    shClk = 1'b0;
    settle();
    checkOut("R6");
    shInhibit = 1'b1;
    settle();
    model = {model[STAGES-2:0], serIn};
    checkOut("R5");
    for (int k = 0; k < 3; k++) begin
      shClk = 1'b1; settle();
      shClk = 1'b0; settle();
      checkOut("R6");
    end
    shInhibit = 1'b0;
    settle();
    checkOut("R6");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule